// File: doc/BRIEF.md
# Power-Down Sequencing Controller

This block takes an audio processing core into a low-power state, and back out of it, in a fixed order whenever software changes a single run/power-down control bit. When the bit goes to 0, the controller first asks the volume path for a soft mute. It waits until the volume path reports that the mute is complete. It then withdraws its permission for the external power stage to run. Finally it drops the clock-enable that feeds the gating cell in front of every internal function except the control interface. When the bit returns to 1, the same steps are undone in reverse order, one step per clock.

Alongside the sequencer, the block holds a separate, directly written power-stage enable bit. This bit is active high: 1 means normal operation and 0 means powered down. It resets to 0. The power-stage enable that leaves the block is the AND of this bit and the sequencer's permission. The same enable can also be routed onto a shared output pin. That routing applies only when a 2-bit output-configuration field selects it. Otherwise the pin carries the signal of its alternate function.

Top module: `pwrdn_seq_ctrl`

## Requirements
- R1: Out of reset the sequencer is in the run state: status is 4'b0001, the mute request is 0, the clock enable is 1, and the direct stage-enable bit is 0, so the stage enable output is 0.
- R2: When the run bit is 0 in the run state, the next clock edge moves the sequencer to the muting state (status 4'b0010) and raises the mute request. The stage enable and clock enable do not change at that edge.
- R3: In the muting state, while the mute-done input stays 0, the sequencer holds its state and keeps the stage permitted.
- R4: With the run bit 0 and mute-done 1 in the muting state, the next edge moves to the stage-off state (status 4'b0100). The stage enable output drops to 0 while the clock enable stays 1.
- R5: With the run bit 0, the stage-off state is followed one edge later by the clock-gated state (status 4'b1000), in which the clock enable is 0. The clock enable only falls after the stage has already been disabled.
- R6: With the run bit 1, the wake-up runs one step per edge. The first edge moves from clock-gated to stage-off and sets the clock enable to 1. The next edge moves to muting and permits the stage again. The edge after that moves to run and clears the mute request.
- R7: If the run bit is 1 while the sequencer is in the muting state and the run state was reached normally, the next edge aborts the sequence and returns to run (status 4'b0001, mute request 0).
- R8: A write strobe loads the direct stage-enable bit at the clock edge. The bit holds its value when no write occurs. The stage enable output is 1 only when the bit is 1 and the sequencer permits the stage.
- R9: The shared pin carries the stage enable output when the output-configuration field equals 2'b10. For any other value it carries the alternate-function input.
- R10: The status output is one-hot. Bit 0 is run, bit 1 is muting, bit 2 is stage-off and bit 3 is clock-gated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control-domain clock (never gated) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_bit | input | 1 | Power-down control bit: 1 run, 0 enter low power |
| mute_done | input | 1 | Volume path reports soft mute reached |
| stage_wr | input | 1 | Write strobe for the direct stage-enable bit |
| stage_wdata | input | 1 | Value written to the direct stage-enable bit |
| out_cfg | input | 2 | Output-configuration field selecting the shared pin function |
| alt_pin_in | input | 1 | Alternate-function signal for the shared pin |
| mute_req | output | 1 | Soft-mute request to the volume path |
| stage_en | output | 1 | Power-stage enable, 1 = running |
| clk_run_en | output | 1 | Enable for the master clock gate, 1 = clocks running |
| shared_pin | output | 1 | Shared external output pin |
| seq_status | output | 4 | One-hot sequencer state |

## Verification
The bench holds mute-done low for a cycle after entering the muting state. A design that skipped the wait would drop the stage while audio was still at full level. It also checks that the clock enable falls one edge after the stage does, and not together with it. On wake-up it samples every edge, so a controller that released everything at once, or in the wrong order, shows a wrong clock or stage value in the middle cycle. It also aborts a sequence during muting, checks both sides of the shared-pin selection, and applies a reset mid-sequence. A latch-style mux or a sticky state would leave a stale pin or status value behind.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN       = 4'b0001,
        ST_MUTING    = 4'b0010,
        ST_STAGE_OFF = 4'b0100,
        ST_CLK_GATED = 4'b1000
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       mute_req;
        logic       stage_ok;
        logic       clk_en;
    } seq_regs_t;

    function automatic seq_regs_t decode_state(seq_state_e st);
        seq_regs_t r;
        r.state    = st;
        r.mute_req = (st != ST_RUN);
        r.stage_ok = (st == ST_RUN) || (st == ST_MUTING);
        r.clk_en   = (st != ST_CLK_GATED);
        return r;
    endfunction

endpackage

// File: rtl/pwrdn_seq_fsm.sv
module pwrdn_seq_fsm
    import pwrdn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_bit,
    input  logic               mute_done,
    output logic               mute_req,
    output logic               stage_ok,
    output logic               clk_en,
    output logic [STATE_W-1:0] state_vec
);

    seq_regs_t regs_d, regs_q;

    always_comb begin
        seq_state_e nxt;
        nxt = regs_q.state;
        unique case (regs_q.state)
            ST_RUN: begin
                if (!run_bit) nxt = ST_MUTING;
            end
            ST_MUTING: begin
                if (run_bit)        nxt = ST_RUN;
                else if (mute_done) nxt = ST_STAGE_OFF;
            end
            ST_STAGE_OFF: begin
                if (run_bit) nxt = ST_MUTING;
                else         nxt = ST_CLK_GATED;
            end
            ST_CLK_GATED: begin
                if (run_bit) nxt = ST_STAGE_OFF;
            end
            default: nxt = ST_RUN;
        endcase
        regs_d = decode_state(nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= decode_state(ST_RUN);
        else        regs_q <= regs_d;
    end

    assign mute_req  = regs_q.mute_req;
    assign stage_ok  = regs_q.stage_ok;
    assign clk_en    = regs_q.clk_en;
    assign state_vec = regs_q.state;

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_vec) == 1); // R10
    AST_MUTE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_req) |-> $past(!run_bit)); // R2
    AST_STAGE_AFTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_ok) |-> $past(mute_req && mute_done)); // R4
    AST_GATE_AFTER_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(!stage_ok)); // R5
    AST_WAKE_CLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> (!stage_ok && mute_req)); // R6
    AST_ABORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vec == ST_MUTING && run_bit) |=> (state_vec == ST_RUN)); // R7

endmodule

// File: rtl/pwrdn_stage_ctl.sv
module pwrdn_stage_ctl #(
    parameter int                 CFG_W   = 2,
    parameter logic [CFG_W-1:0]   PIN_SEL = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_data,
    input  logic             stage_ok,
    input  logic [CFG_W-1:0] out_cfg,
    input  logic             alt_in,
    output logic             stage_en,
    output logic             pin_out
);

    typedef struct packed {
        logic en_bit;
    } stage_regs_t;

    stage_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d.en_bit = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign stage_en = regs_q.en_bit & stage_ok;
    assign pin_out  = (out_cfg == PIN_SEL) ? stage_en : alt_in;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q.en_bit)); // R8
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q.en_bit == $past(wr_data))); // R8

endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl
    import pwrdn_pkg::*;
#(
    parameter int                 CFG_W   = 2,
    parameter logic [CFG_W-1:0]   PIN_SEL = 2'b10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_bit,
    input  logic               mute_done,
    input  logic               stage_wr,
    input  logic               stage_wdata,
    input  logic [CFG_W-1:0]   out_cfg,
    input  logic               alt_pin_in,
    output logic               mute_req,
    output logic               stage_en,
    output logic               clk_run_en,
    output logic               shared_pin,
    output logic [STATE_W-1:0] seq_status
);

    logic stage_ok;

    pwrdn_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_bit   (run_bit),
        .mute_done (mute_done),
        .mute_req  (mute_req),
        .stage_ok  (stage_ok),
        .clk_en    (clk_run_en),
        .state_vec (seq_status)
    );

    pwrdn_stage_ctl #(
        .CFG_W   (CFG_W),
        .PIN_SEL (PIN_SEL)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stage_wr),
        .wr_data  (stage_wdata),
        .stage_ok (stage_ok),
        .out_cfg  (out_cfg),
        .alt_in   (alt_pin_in),
        .stage_en (stage_en),
        .pin_out  (shared_pin)
    );

    AST_NO_STAGE_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run_en |-> !stage_en); // R5
    AST_NO_STAGE_UNMUTED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_en) && !$past(stage_wr) |-> mute_req); // R4

endmodule

// File: tb/pwrdn_seq_ctrl_test.sv
module pwrdn_seq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_bit = 1'b1;
    logic       mute_done = 1'b0;
    logic       stage_wr = 1'b0;
    logic       stage_wdata = 1'b0;
    logic [1:0] out_cfg = 2'b00;
    logic       alt_pin_in = 1'b0;
    logic       mute_req, stage_en, clk_run_en, shared_pin;
    logic [3:0] seq_status;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwrdn_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .mute_done(mute_done),
        .stage_wr(stage_wr), .stage_wdata(stage_wdata), .out_cfg(out_cfg),
        .alt_pin_in(alt_pin_in), .mute_req(mute_req), .stage_en(stage_en),
        .clk_run_en(clk_run_en), .shared_pin(shared_pin), .seq_status(seq_status)
    );

    // [14]run [13]mute_done [12]wr [11]wdata [10:9]cfg [8]alt |
    // [7:4]status [3]mute_req [2]stage_en [1]clk_run_en [0]shared_pin
    localparam int NVEC = 14;
    localparam logic [14:0] VEC [NVEC] = '{
        15'b1_0_1_1_00_0_0001_0_1_1_0, // R8 write enable bit, pin on alternate
        15'b1_0_0_0_10_0_0001_0_1_1_1, // R9 pin follows stage enable
        15'b0_0_0_0_10_0_0010_1_1_1_1, // R2 enter muting
        15'b0_0_0_0_10_0_0010_1_1_1_1, // R3 wait for mute
        15'b0_1_0_0_10_0_0100_1_0_1_0, // R4 stage off
        15'b0_1_0_0_10_0_1000_1_0_0_0, // R5 clocks gated
        15'b0_0_0_0_10_0_1000_1_0_0_0, // R5 hold gated
        15'b1_0_0_0_10_0_0100_1_0_1_0, // R6 clock released first
        15'b1_0_0_0_10_0_0010_1_1_1_1, // R6 stage re-enabled
        15'b1_0_0_0_10_0_0001_0_1_1_1, // R6 mute released
        15'b0_0_0_0_10_0_0010_1_1_1_1, // R2 muting again
        15'b1_0_0_0_10_0_0001_0_1_1_1, // R7 abort
        15'b1_0_1_0_10_1_0001_0_0_1_0, // R8 clear enable bit
        15'b1_0_0_0_01_1_0001_0_0_1_1  // R9 alternate function
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {4'd0, seq_status}, 8'h01);
        check("R1", {7'd0, mute_req}, 8'h0);
        check("R1", {7'd0, clk_run_en}, 8'h1);
        check("R1", {7'd0, stage_en}, 8'h0);

        for (int i = 0; i < NVEC; i++) begin
            run_bit     = VEC[i][14];
            mute_done   = VEC[i][13];
            stage_wr    = VEC[i][12];
            stage_wdata = VEC[i][11];
            out_cfg     = VEC[i][10:9];
            alt_pin_in  = VEC[i][8];
            @(negedge clk);
            check($sformatf("R10 vec%0d status", i), {4'd0, seq_status}, {4'd0, VEC[i][7:4]});
            check($sformatf("R2 vec%0d mute_req", i), {7'd0, mute_req}, {7'd0, VEC[i][3]});
            check($sformatf("R8 vec%0d stage_en", i), {7'd0, stage_en}, {7'd0, VEC[i][2]});
            check($sformatf("R5 vec%0d clk_run_en", i), {7'd0, clk_run_en}, {7'd0, VEC[i][1]});
            check($sformatf("R9 vec%0d shared_pin", i), {7'd0, shared_pin}, {7'd0, VEC[i][0]});
        end

        // R8: stage enable bit holds 1 without further writes
        stage_wr = 1'b1; stage_wdata = 1'b1; out_cfg = 2'b10;
        @(negedge clk);
        stage_wr = 1'b0; stage_wdata = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 hold", {7'd0, stage_en}, 8'h1);
        check("R9 sel", {7'd0, shared_pin}, 8'h1);

        // R1: reset in the middle of a sequence
        run_bit = 1'b0;
        @(negedge clk);
        check("R2 pre-reset", {4'd0, seq_status}, 8'h02);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset status", {4'd0, seq_status}, 8'h01);
        check("R1 mid reset stage", {7'd0, stage_en}, 8'h0);
        check("R1 mid reset mute", {7'd0, mute_req}, 8'h0);
        run_bit = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {4'd0, seq_status}, 8'h01);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule